// File: doc/BRIEF.md
# Phase-Adjustable Clock Divider and Slot Sampler

This block runs entirely from one fast clock (256 MHz in the intended system). A free-running slot counter splits time into frames of 16 fast cycles. A toggle register, flipped whenever the low two bits of the counter roll over, produces a divided clock with an 8-cycle period. Because this output comes from a register in the fast domain, its edges sit at known positions relative to everything else the block does.

An asynchronous enable from a slow video source (16 MHz, one source period per frame) first crosses a two-flop synchronizer. It is then captured once per frame, in the slot named by a 4-bit phase select. Moving the phase select shifts the capture point in steps of one fast cycle. This lets integration logic align the capture to the slow source without tuning any delay element. Each capture raises a one-cycle strobe beside the held sample. A new phase value is taken up only at a frame boundary, so every frame still yields exactly one capture.

Top module: `slot_phase_sampler`

## Requirements
- R1: While `rst` is high at a rising edge, the slot counter returns to slot 0 and `div_clk_out`, `en_sample` and `sample_pulse` become 0.
- R2: Number the cycles after the last reset edge n = 0, 1, 2, ... The value of `div_clk_out` in cycle n equals bit 2 of n: low for 4 cycles, then high for 4 cycles, repeating every 8 cycles.
- R3: Each window of cycles n = 16k+1 through 16k+16 contains exactly one cycle with `sample_pulse` high, including frames in which the phase select changed.
- R4: `sample_pulse` is high in cycle n exactly when (n-1) mod 16 equals the active phase, and it stays high for one cycle only.
- R5: `en_sample` changes only in a cycle where `sample_pulse` is high, and otherwise holds its value.
- R6: In a strobe cycle n with n >= 3, `en_sample` equals the value `en_async` held in cycle n-3. For n < 3 it is 0. This latency is the same for every phase value.
- R7: The active phase is reloaded from `phase_sel` only at the edge that moves the counter from slot 15 to slot 0. A change of `phase_sel` in the middle of a frame does not move that frame's capture.
- R8: While `rst` is high, the active phase is loaded from `phase_sel`, so the first frame after reset already uses the selected slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_sel | input | 4 | Capture slot request, 0 to 15, taken up at frame start |
| en_async | input | 1 | Asynchronous enable from the slow source |
| div_clk_out | output | 1 | Divided clock, 8 fast cycles per period, registered |
| en_sample | output | 1 | Enable value held from the last capture |
| sample_pulse | output | 1 | One-cycle pulse in the cycle after a capture |

## Verification
The assertions check on every cycle that the counter steps by one and that the divided clock changes only on a 4-slot boundary. They also check that the held sample moves only with the strobe, that the strobe follows the slot match, and that the active phase changes only at slot 0. Only the bench scenarios can show the end-to-end results. These are the 3-cycle capture latency under several phase values, one capture per frame across mid-frame phase changes (including a move from slot 15 to slot 0), and the slot used in the first frame after a reset.

// File: rtl/slot_phase_pkg.sv
package slot_phase_pkg;
  // Defaults shared by the top and its submodules
  localparam int unsigned DEF_SLOT_BITS   = 4;  // 16 slots per frame
  localparam int unsigned DEF_HALF_BITS   = 2;  // toggle every 4 slots
  localparam int unsigned DEF_SYNC_STAGES = 2;  // synchronizer depth

  // True when the low 'bits' of a slot value are all ones
  function automatic logic low_bits_full(input logic [31:0] v, input int unsigned bits);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(bits)) r = r & v[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int unsigned SLOT_BITS = slot_phase_pkg::DEF_SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [SLOT_BITS-1:0] slot,
  output logic                 frame_last
);
  localparam logic [SLOT_BITS-1:0] SLOT_MAX = {SLOT_BITS{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + SLOT_BITS'(1);
  end

  assign frame_last = (slot == SLOT_MAX);

  // R2: the counter advances by exactly one per fast cycle
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (slot == $past(slot) + SLOT_BITS'(1)));
endmodule

// File: rtl/toggle_divider.sv
module toggle_divider #(
  parameter int unsigned SLOT_BITS = slot_phase_pkg::DEF_SLOT_BITS,
  parameter int unsigned HALF_BITS = slot_phase_pkg::DEF_HALF_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOT_BITS-1:0] slot,
  output logic                 div_q
);
  logic roll;

  assign roll = slot_phase_pkg::low_bits_full(32'(slot), HALF_BITS);

  always_ff @(posedge clk) begin
    if (rst)       div_q <= 1'b0;
    else if (roll) div_q <= ~div_q;
  end

  // R2: the divided clock only changes as the low bits roll to zero
  assert_clk_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (div_q != $past(div_q))) |-> (slot[HALF_BITS-1:0] == '0));
endmodule

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES = slot_phase_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= 1'b0;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= 1'b0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/slot_capture.sv
module slot_capture #(
  parameter int unsigned SLOT_BITS = slot_phase_pkg::DEF_SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOT_BITS-1:0] slot,
  input  logic                 frame_last,
  input  logic [SLOT_BITS-1:0] phase_req,
  input  logic                 din_sync,
  output logic                 held,
  output logic                 pulse
);
  logic [SLOT_BITS-1:0] phase_act;
  logic                 hit;

  assign hit = (slot == phase_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_act <= phase_req;
      held      <= 1'b0;
      pulse     <= 1'b0;
    end else begin
      pulse <= hit;
      if (hit)        held      <= din_sync;
      if (frame_last) phase_act <= phase_req;
    end
  end

  // R5: the held sample moves only alongside the strobe
  assert_sample_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !pulse) |-> (held == $past(held)));

  // R4: a strobe follows a slot match with the active phase
  assert_strobe_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pulse) |-> ($past(slot) == $past(phase_act)));

  // R7: the active phase is only replaced at the start of a frame
  assert_phase_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (phase_act != $past(phase_act))) |-> (slot == '0));
endmodule

// File: rtl/slot_phase_sampler.sv
module slot_phase_sampler #(
  parameter int unsigned SLOT_BITS   = slot_phase_pkg::DEF_SLOT_BITS,
  parameter int unsigned HALF_BITS   = slot_phase_pkg::DEF_HALF_BITS,
  parameter int unsigned SYNC_STAGES = slot_phase_pkg::DEF_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLOT_BITS-1:0] phase_sel,
  input  logic                 en_async,
  output logic                 div_clk_out,
  output logic                 en_sample,
  output logic                 sample_pulse
);
  logic [SLOT_BITS-1:0] slot;
  logic                 frame_last;
  logic                 en_sync;

  slot_counter #(.SLOT_BITS(SLOT_BITS)) u_count (
    .clk(clk), .rst(rst), .slot(slot), .frame_last(frame_last)
  );

  toggle_divider #(.SLOT_BITS(SLOT_BITS), .HALF_BITS(HALF_BITS)) u_div (
    .clk(clk), .rst(rst), .slot(slot), .div_q(div_clk_out)
  );

  sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(en_async), .q(en_sync)
  );

  slot_capture #(.SLOT_BITS(SLOT_BITS)) u_cap (
    .clk(clk), .rst(rst), .slot(slot), .frame_last(frame_last),
    .phase_req(phase_sel), .din_sync(en_sync),
    .held(en_sample), .pulse(sample_pulse)
  );

  // R1: outputs come out of reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!div_clk_out && !en_sample && !sample_pulse && slot == '0));
endmodule

// File: tb/tb_slot_phase_sampler.sv
module tb_slot_phase_sampler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] phase_sel = 4'd5;
  logic       en_async = 1'b0;
  logic       div_clk_out, en_sample, sample_pulse;

  int checks = 0;
  int fails  = 0;
  int frame_hits = 0;
  int tb_cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slot_phase_sampler dut (
    .clk(clk), .rst(rst), .phase_sel(phase_sel), .en_async(en_async),
    .div_clk_out(div_clk_out), .en_sample(en_sample), .sample_pulse(sample_pulse)
  );

  // Reference built from R2, R4, R6, R7, R8
  int unsigned n_cyc;
  logic [3:0]  ph_ref;
  logic [2:0]  hist;
  logic        exp_pulse, exp_held;

  always @(posedge clk) begin
    if (rst) begin
      n_cyc <= 0; ph_ref <= phase_sel; hist <= '0;
      exp_pulse <= 1'b0; exp_held <= 1'b0;
    end else begin
      n_cyc <= n_cyc + 1;
      hist  <= {hist[1:0], en_async};
      if (n_cyc[3:0] == ph_ref) begin
        exp_pulse <= 1'b1;
        exp_held  <= hist[1];
      end else begin
        exp_pulse <= 1'b0;
      end
      if (n_cyc[3:0] == 4'd15) ph_ref <= phase_sel;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, n_cyc, act, exp);
    end
  endtask

  // One cycle: compare at the falling edge, then drive new inputs
  task automatic step(input int mode, input int ofs);
    @(negedge clk);
    check(rst ? "R1 div" : "R2 div", div_clk_out, rst ? 1'b0 : n_cyc[2]);
    check(rst ? "R1 pulse" : "R4/R7/R8 pulse", sample_pulse, exp_pulse);
    check(rst ? "R1 sample" : "R5/R6 sample", en_sample, exp_held);
    if (rst) frame_hits = 0;
    else begin
      if (sample_pulse) frame_hits++;
      if (n_cyc[3:0] == 4'd0 && n_cyc != 0) begin
        checks++;
        if (frame_hits != 1) begin
          fails++;
          $display("FAIL R3 frame ending %0d: actual %0d strobes expected 1", n_cyc, frame_hits);
        end
        frame_hits = 0;
      end
    end
    tb_cyc++;
    if (mode == 0) en_async = 1'($urandom);
    else           en_async = 1'(((tb_cyc + ofs) / 16) % 2);
  endtask

  task automatic run(input int k, input int mode, input int ofs);
    for (int i = 0; i < k; i++) step(mode, ofs);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1/R8: reset with random input, phase 5 loaded during reset
    phase_sel = 4'd5;
    run(6, 0, 0);
    rst = 1'b0;
    run(48, 0, 0);
    // R6 with slow source pattern at several phases
    phase_sel = 4'd0;  run(64, 1, 3);
    phase_sel = 4'd15; run(64, 1, 9);
    phase_sel = 4'd7;  run(64, 1, 0);
    // R7/R3: change from 15 to 0 mid-frame, and back again
    phase_sel = 4'd15; run(40, 0, 0);
    phase_sel = 4'd0;  run(7, 0, 0);
    phase_sel = 4'd15; run(40, 0, 0);
    // R1: mid-run reset with non-zero state, phase 11 for first frame (R8)
    rst = 1'b1; phase_sel = 4'd3; run(3, 0, 0);
    phase_sel = 4'd11; run(1, 0, 0);
    rst = 1'b0; run(40, 0, 0);
    // Random phase changes at random times
    for (int r = 0; r < 60; r++) begin
      phase_sel = 4'($urandom);
      run(1 + int'($urandom % 23), int'($urandom % 2), int'($urandom % 16));
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule